// File: doc/BRIEF.md
# Processor Supervisor with Watchdog

This block produces the reset and protection signals around a processor. It takes flags that are already digital: supply above the reset threshold, power-fail comparator low, and watchdog enabled. It also takes the raw watchdog service pin and a RAM chip-enable request. From these it drives an active-low reset and its active-high twin, a sticky watchdog-fault flag, a power-fail warning and a gated RAM chip-enable. Every duration is counted in cycles of a free-running clock.

A single reset stretcher serves both sources. A supply dropout holds reset for as long as it lasts and then for a fixed hold period. Watchdog expiry starts a pulse of the same width. Software services the watchdog by toggling its pin in either direction. If the pin stays quiet, a new reset pulse follows every timeout period. The fault flag stays low until the pin moves again.

Top module: `proc_supervisor`

## Requirements
- R1: While `supply_ok_i` is 0, `rst_n_o` is 0 in the same cycle, whatever the other inputs.
- R2: After `supply_ok_i` rises, `rst_n_o` goes to 1 at the HOLD_CYC-th rising clock edge that samples `supply_ok_i` high. Any low sample before then restarts that count.
- R3: `rst_o` is always the inverse of `rst_n_o`.
- R4: A level change on `wd_pin_i` in either direction clears the watchdog count; the change takes effect on the third rising edge after it. If the count reaches WD_TIMEOUT_CYC without a change, reset asserts for exactly HOLD_CYC cycles.
- R5: While the pin stays unchanged, a watchdog reset starts every WD_TIMEOUT_CYC cycles, measured from the start of one pulse to the start of the next.
- R6: `wd_fault_n_o` goes to 0 on the edge at which a watchdog reset starts. It stays 0 through later watchdog resets until a pin change takes effect.
- R7: While `wd_en_i` is 0, no watchdog reset occurs and `wd_fault_n_o` is 1.
- R8: `ram_ce_n_o` equals `ram_ce_n_i` while `supply_ok_i` is 1 and is 1 while `supply_ok_i` is 0.
- R9: `pwr_fail_n_o` is the inverse of `pwr_low_i` at all times, independent of reset.
- R10: While `rst_ni` is 0, `rst_n_o` is 0, `rst_o` is 1 and `wd_fault_n_o` is 1.
- R11: The watchdog count is held at zero while a supply-caused reset is in progress. The first watchdog reset starts WD_TIMEOUT_CYC cycles after that reset releases.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Free-running clock |
| rst_ni | input | 1 | Asynchronous active-low block reset |
| supply_ok_i | input | 1 | Supply above reset threshold |
| pwr_low_i | input | 1 | Monitored voltage below power-fail threshold |
| wd_en_i | input | 1 | Watchdog enabled (0 models an open pin) |
| wd_pin_i | input | 1 | Asynchronous watchdog service pin |
| ram_ce_n_i | input | 1 | RAM chip-enable request, active low |
| rst_n_o | output | 1 | Processor reset, active low |
| rst_o | output | 1 | Processor reset, active high |
| wd_fault_n_o | output | 1 | Watchdog fault, active low, sticky |
| pwr_fail_n_o | output | 1 | Power-fail warning, active low |
| ram_ce_n_o | output | 1 | Gated RAM chip-enable, active low |

## Verification
The assertions check the per-cycle rules on every cycle:
- reset is captured whenever the supply is low;
- the stretcher releases only at the end of its count;
- the watchdog count stays in range and restarts after an expiry;
- the fault flag holds until a pin change;
- no expiry happens while the watchdog is disabled.

Exact cycle counts need the bench's scenarios. These include the hold width after supply recovery, the restart after a dropout in mid-hold, the gap from release to the first watchdog pulse, the repeat period and the three-edge service latency. The random mix of dropouts, service gaps and enable changes is compared cycle by cycle against the bench's own model.

// File: rtl/sup_pkg.sv
package sup_pkg;
  localparam int unsigned SYNC_STAGES = 2;

  function automatic int unsigned cnt_w(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/sup_sync.sv
module sup_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic edge_o
);
  logic [STAGES:0] sh_q;

  for (genvar i = 0; i <= STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sh_q[0] <= 1'b0;
        else         sh_q[0] <= d_i;
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sh_q[i] <= 1'b0;
        else         sh_q[i] <= sh_q[i-1];
    end
  end

  // last stage is a delay copy used only for change detection
  assign edge_o = sh_q[STAGES] ^ sh_q[STAGES-1];
endmodule

// File: rtl/sup_stretch.sv
module sup_stretch #(
  parameter int unsigned HOLD_CYC = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic supply_ok_i,
  input  logic trig_i,
  output logic active_o,
  output logic por_busy_o
);
  localparam int unsigned W = sup_pkg::cnt_w(HOLD_CYC);
  localparam logic [W-1:0] HOLD_LAST = W'(HOLD_CYC - 1);

  logic [W-1:0] cnt_q;
  logic         active_q, por_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      active_q <= 1'b1;
      por_q    <= 1'b1;
    end else if (!supply_ok_i) begin
      cnt_q    <= '0;
      active_q <= 1'b1;
      por_q    <= 1'b1;
    end else if (trig_i) begin
      cnt_q    <= '0;
      active_q <= 1'b1;
    end else if (active_q) begin
      if (cnt_q == HOLD_LAST) begin
        active_q <= 1'b0;
        por_q    <= 1'b0;
        cnt_q    <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign active_o   = active_q;
  assign por_busy_o = por_q;

  p_capture_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !supply_ok_i |=> (active_q && por_q));
  p_hold_end_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_q && supply_ok_i && !trig_i && cnt_q == HOLD_LAST) |=> !active_q);
  p_release_ok_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_q && !(cnt_q == HOLD_LAST)) |=> active_q);
endmodule

// File: rtl/sup_watchdog.sv
module sup_watchdog #(
  parameter int unsigned TIMEOUT_CYC = 64
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic supply_ok_i,
  input  logic por_busy_i,
  input  logic edge_i,
  output logic expire_o,
  output logic fault_n_o
);
  localparam int unsigned W = sup_pkg::cnt_w(TIMEOUT_CYC);
  localparam logic [W-1:0] TO_LAST = W'(TIMEOUT_CYC - 1);

  logic [W-1:0] cnt_q;
  logic         fault_n_q, run;

  assign run      = en_i && supply_ok_i && !por_busy_i;
  assign expire_o = run && !edge_i && (cnt_q == TO_LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   cnt_q <= '0;
    else if (!run || edge_i)       cnt_q <= '0;
    else if (cnt_q == TO_LAST)     cnt_q <= '0;
    else                           cnt_q <= cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 fault_n_q <= 1'b1;
    else if (!en_i || edge_i)    fault_n_q <= 1'b1;
    else if (expire_o)           fault_n_q <= 1'b0;
  end

  assign fault_n_o = fault_n_q;

  p_cnt_bound_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= TO_LAST);
  p_restart_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire_o |=> (cnt_q == '0));
  p_fault_sticky_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!fault_n_q && en_i && !edge_i) |=> !fault_n_q);
  p_quiet_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |-> !expire_o);
  p_por_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    por_busy_i |=> (cnt_q == '0));
endmodule

// File: rtl/proc_supervisor.sv
module proc_supervisor #(
  parameter int unsigned HOLD_CYC       = 6_250_000,
  parameter int unsigned WD_TIMEOUT_CYC = 200_000_000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic supply_ok_i,
  input  logic pwr_low_i,
  input  logic wd_en_i,
  input  logic wd_pin_i,
  input  logic ram_ce_n_i,
  output logic rst_n_o,
  output logic rst_o,
  output logic wd_fault_n_o,
  output logic pwr_fail_n_o,
  output logic ram_ce_n_o
);
  logic wd_edge, expire, active, por_busy;

  sup_sync #(.STAGES(sup_pkg::SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .d_i(wd_pin_i), .edge_o(wd_edge)
  );

  sup_stretch #(.HOLD_CYC(HOLD_CYC)) u_stretch (
    .clk_i, .rst_ni, .supply_ok_i, .trig_i(expire),
    .active_o(active), .por_busy_o(por_busy)
  );

  sup_watchdog #(.TIMEOUT_CYC(WD_TIMEOUT_CYC)) u_wdog (
    .clk_i, .rst_ni, .en_i(wd_en_i), .supply_ok_i, .por_busy_i(por_busy),
    .edge_i(wd_edge), .expire_o(expire), .fault_n_o(wd_fault_n_o)
  );

  assign rst_n_o      = !active && supply_ok_i;
  assign rst_o        = !rst_n_o;
  assign pwr_fail_n_o = !pwr_low_i;
  assign ram_ce_n_o   = ram_ce_n_i || !supply_ok_i;

  p_expire_resets_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire |=> !rst_n_o);
  p_ram_guard_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rst_n_o && !active |-> ram_ce_n_o);
endmodule

// File: tb/proc_supervisor_bench.sv
module proc_supervisor_bench;
  localparam int unsigned H  = 12;
  localparam int unsigned TO = 40;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic sup = 1'b0, pwr_low = 1'b0, en = 1'b0, pin = 1'b0, ce_in = 1'b1;
  logic rst_n_o, rst_o, fault_n_o, pf_n_o, ce_n_o;

  int unsigned n_vec = 0, n_bad = 0;

  // bench model state
  logic m_act = 1'b1, m_por = 1'b1, m_fault_n = 1'b1;
  int   m_cnt = 0, w_cnt = 0;
  logic p1 = 1'b0, p2 = 1'b0, p3 = 1'b0;

  always #4 clk = ~clk;

  proc_supervisor #(.HOLD_CYC(H), .WD_TIMEOUT_CYC(TO)) u_proc_supervisor (
    .clk_i(clk), .rst_ni, .supply_ok_i(sup), .pwr_low_i(pwr_low),
    .wd_en_i(en), .wd_pin_i(pin), .ram_ce_n_i(ce_in),
    .rst_n_o, .rst_o, .wd_fault_n_o(fault_n_o), .pwr_fail_n_o(pf_n_o),
    .ram_ce_n_o(ce_n_o)
  );

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic exp_rst_n();
    return !m_act && sup;
  endfunction

  function automatic logic exp_ce_n();
    return sup ? ce_in : 1'b1;
  endfunction

  task automatic model_edge();
    logic edg, run, trig;
    edg  = p2 ^ p3;
    run  = en && sup && !m_por;
    trig = run && !edg && (w_cnt == TO - 1);
    if (!en || edg)  m_fault_n = 1'b1;
    else if (trig)   m_fault_n = 1'b0;
    if (!run || edg || trig) w_cnt = 0; else w_cnt++;
    if (!sup) begin m_act = 1'b1; m_por = 1'b1; m_cnt = 0; end
    else if (trig) begin m_act = 1'b1; m_cnt = 0; end
    else if (m_act) begin
      if (m_cnt == H - 1) begin m_act = 1'b0; m_por = 1'b0; m_cnt = 0; end
      else m_cnt++;
    end
    p3 = p2; p2 = p1; p1 = pin;
  endtask

  task automatic step();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    check(rst_n_o == exp_rst_n(), "R2/R4 rst_n_o", rst_n_o, exp_rst_n());
    check(rst_o == !rst_n_o, "R3 rst_o", rst_o, !rst_n_o);
    check(fault_n_o == m_fault_n, "R6 wd_fault_n_o", fault_n_o, m_fault_n);
    check(pf_n_o == !pwr_low, "R9 pwr_fail_n_o", pf_n_o, !pwr_low);
    check(ce_n_o == exp_ce_n(), "R8 ram_ce_n_o", ce_n_o, exp_ce_n());
  endtask

  initial begin : watchdog_timer
    #(8 * 200000);
    n_bad++;
    $display("FAIL watchdog: run did not finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin : main
    int n;
    void'($urandom(32'h5EED_0017));
    // R10 safe state in reset
    sup = 1'b1; ce_in = 1'b0;
    repeat (3) @(negedge clk);
    check(rst_n_o == 1'b0, "R10 rst_n_o in reset", rst_n_o, 0);
    check(rst_o == 1'b1, "R10 rst_o in reset", rst_o, 1);
    check(fault_n_o == 1'b1, "R10 fault in reset", fault_n_o, 1);
    sup = 1'b0;
    @(negedge clk);
    check(ce_n_o == 1'b1, "R8 ce forced high", ce_n_o, 1);
    rst_ni = 1'b1;
    repeat (3) step();
    check(rst_n_o == 1'b0, "R1 supply low holds reset", rst_n_o, 0);

    // R2 hold width
    sup = 1'b1;
    n = 0;
    do begin step(); n++; end while (!rst_n_o && n < 4 * H);
    check(n == H, "R2 hold width", n, H);

    // R2 dropout restarts hold
    sup = 1'b0; step(); sup = 1'b1;
    repeat (H / 2) step();
    sup = 1'b0; pwr_low = 1'b1; step();
    check(rst_n_o == 1'b0, "R1 dropout asserts", rst_n_o, 0);
    check(pf_n_o == 1'b0, "R9 power fail", pf_n_o, 0);
    sup = 1'b1; pwr_low = 1'b0;
    n = 0;
    do begin step(); n++; end while (!rst_n_o && n < 4 * H);
    check(n == H, "R2 hold restarted", n, H);

    // R11 first timeout from release, R4 width, R5 period, R6 sticky
    en = 1'b1;
    sup = 1'b0; step(); sup = 1'b1;
    do step(); while (!rst_n_o);
    n = 0;
    do begin step(); n++; end while (rst_n_o && n < 4 * TO);
    check(n == TO, "R11 first watchdog reset", n, TO);
    check(fault_n_o == 1'b0, "R6 fault on expiry", fault_n_o, 0);
    n = 0;
    do begin step(); n++; end while (!rst_n_o && n < 4 * TO);
    check(n == H, "R4 watchdog pulse width", n, H);
    do begin step(); n++; end while (rst_n_o && n < 4 * TO);
    check(n == TO, "R5 repeat period", n, TO);
    check(fault_n_o == 1'b0, "R6 fault held across resets", fault_n_o, 0);

    // R4 service: change takes effect on third edge
    pin = ~pin;
    step(); step();
    check(fault_n_o == 1'b0, "R6 fault before sync", fault_n_o, 0);
    step();
    check(fault_n_o == 1'b1, "R6 fault cleared by service", fault_n_o, 1);

    // R7 disabled watchdog
    repeat (2 * H) step();
    en = 1'b0;
    n = 0;
    repeat (3 * TO) begin step(); if (!rst_n_o || !fault_n_o) n++; end
    check(n == 0, "R7 disabled quiet", n, 0);

    // R8 passthrough
    ce_in = 1'b0; step();
    check(ce_n_o == 1'b0, "R8 ce follows", ce_n_o, 0);

    // random mix
    for (int seg = 0; seg < 200; seg++) begin
      int len = 10 + int'($urandom % 60);
      int gap = int'($urandom % 2) ? 1 + int'($urandom % (TO / 2)) : TO + int'($urandom % TO);
      if ($urandom % 8 == 0) en = ~en;
      for (int c = 0; c < len; c++) begin
        if ($urandom % 150 == 0) sup = 1'b0;
        else if (!sup && $urandom % 4 == 0) sup = 1'b1;
        pwr_low = ($urandom % 10 == 0);
        ce_in   = $urandom % 2;
        if (c % gap == gap - 1) pin = ~pin;
        step();
      end
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule